// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit datapath. It is built around an accumulator. Each operation takes its first operand from the accumulator and its second from an 8-bit operand input, which can carry a register value or an immediate. On a one-cycle execute strobe the block computes the result. For every operation except compare, it writes that result back into the accumulator. It then updates a five-flag status byte: sign, zero, auxiliary (nibble) carry, parity and carry.

The operations are add, add with carry, subtract, subtract with borrow, AND, OR, XOR, compare, and four single-bit rotates of the accumulator. Two rotates go around the accumulator and two go through the carry flag. The status byte is always visible at an output. A separate load port can overwrite it as a whole byte, so surrounding control logic can save and restore the flags. The block has no accumulator load port. To set the accumulator to a value V, issue AND with 0x00 and then OR with V.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted and just after it is released, the accumulator and the status byte are both 0x00.
- R2: On a cycle with execute high, op codes 0 (ADD), 1 (ADC), 2 (SUB), 3 (SBB), 4 (AND), 5 (OR) and 6 (XOR) combine the accumulator with the operand and write the 8-bit result to the accumulator. The new value is visible on the cycle after the strobe.
- R3: The carry flag (status bit 0) is set when an addition gives a sum above 255, or when a subtraction needs a borrow (unsigned accumulator smaller than operand plus borrow-in). ADC and SBB add or subtract the carry flag as it stood before the operation. ADD and SUB use 0 as the carry-in.
- R4: After any operation other than a rotate, zero (bit 6) is 1 exactly when the result is 0x00, and sign (bit 7) equals bit 7 of the result.
- R5: After any operation other than a rotate, parity (bit 2) is 1 exactly when the result has an even number of 1 bits.
- R6: Auxiliary carry (bit 4) is the carry out of bit 3 in an addition, or the borrow into bit 3 from bit 4 in a subtraction or compare. Each includes the carry or borrow input.
- R7: AND, OR and XOR clear both carry and auxiliary carry.
- R8: Compare (op 7) sets every flag exactly as SUB with the same operand would, and leaves the accumulator unchanged.
- R9: The rotates are op 8 (left, bit 7 into bit 0), op 9 (right, bit 0 into bit 7), op 10 (left through carry) and op 11 (right through carry). In each one, the bit shifted out becomes the carry. They leave sign, zero, auxiliary carry and parity unchanged.
- R10: Status bits 5, 3 and 1 always read 0. When flag load is high, the status byte becomes the flag input with those three bits forced to 0.
- R11: When flag load and execute are high in the same cycle, the loaded byte wins over the operation's flag update. The accumulator still takes the operation's result.
- R12: Op codes 12 to 15 with execute high, or any cycle with both execute and flag load low, change neither the accumulator nor the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| exec | input | 1 | Execute strobe: perform `op` this cycle |
| op | input | 4 | Operation select code (see R2, R8, R9, R12) |
| operand | input | 8 | Second operand (register or immediate value) |
| flag_ld | input | 1 | Load the status byte from `flag_in` |
| flag_in | input | 8 | Status byte value for a load |
| acc_q | output | 8 | Accumulator contents |
| flag_q | output | 8 | Status byte: S=7, Z=6, AC=4, P=2, CY=0 |

## Verification
The bound properties assume that `exec`, `flag_ld` and `op` are never unknown once reset has been released. They also read the status byte only on the cycle after the event that produced it, so they take a clean single-cycle registered path for granted. The bench drives every input from defined values only. It uses all sixteen op codes, including the reserved ones, and raises flag loads at random, sometimes together with an execute. This gives the properties that exempt a load cycle real cases to pass over. Operands and flag-load bytes are full 8-bit random values, so carry, borrow and nibble boundaries are reached along with the directed corner values.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMP = 4'd7,
    OP_RLC = 4'd8,
    OP_RRC = 4'd9,
    OP_RAL = 4'd10,
    OP_RAR = 4'd11
  } alu_op_e;

  localparam int FLAG_W = 8;
  localparam int FB_S   = 7;
  localparam int FB_Z   = 6;
  localparam int FB_AC  = 4;
  localparam int FB_P   = 2;
  localparam int FB_CY  = 0;
  localparam logic [FLAG_W-1:0] FLAG_MASK = 8'hD5;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  function automatic logic [FLAG_W-1:0] pack_flags(input flags_t f);
    logic [FLAG_W-1:0] b;
    b        = '0;
    b[FB_S]  = f.s;
    b[FB_Z]  = f.z;
    b[FB_AC] = f.ac;
    b[FB_P]  = f.p;
    b[FB_CY] = f.cy;
    return b;
  endfunction

  function automatic flags_t unpack_flags(input logic [FLAG_W-1:0] b);
    flags_t f;
    f.s  = b[FB_S];
    f.z  = b[FB_Z];
    f.ac = b[FB_AC];
    f.p  = b[FB_P];
    f.cy = b[FB_CY];
    return f;
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] res,
  output logic              carry,
  output logic              half
);
  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W:0] wide_sum(
    input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y,
    input logic c, input logic minus);
    logic [DATA_W:0] xe, ye, ce;
    xe = {1'b0, x};
    ye = {1'b0, y};
    ce = {{DATA_W{1'b0}}, c};
    return minus ? (xe - ye - ce) : (xe + ye + ce);
  endfunction

  function automatic logic [HALF_W:0] nib_sum(
    input logic [HALF_W-1:0] x, input logic [HALF_W-1:0] y,
    input logic c, input logic minus);
    logic [HALF_W:0] xe, ye, ce;
    xe = {1'b0, x};
    ye = {1'b0, y};
    ce = {{HALF_W{1'b0}}, c};
    return minus ? (xe - ye - ce) : (xe + ye + ce);
  endfunction

  logic [DATA_W:0] full_w;
  logic [HALF_W:0] low_w;

  always_comb begin
    full_w = wide_sum(a, b, cin, sub);
    low_w  = nib_sum(a[HALF_W-1:0], b[HALF_W-1:0], cin, sub);
    res    = full_w[DATA_W-1:0];
    carry  = full_w[DATA_W];
    half   = low_w[HALF_W];
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  always_comb begin
    res  = a;
    cout = cin;
    unique case (op)
      OP_AND: begin res = a & b; cout = 1'b0; end
      OP_OR:  begin res = a | b; cout = 1'b0; end
      OP_XOR: begin res = a ^ b; cout = 1'b0; end
      OP_RLC: begin res = {a[DATA_W-2:0], a[DATA_W-1]}; cout = a[DATA_W-1]; end
      OP_RRC: begin res = {a[0], a[DATA_W-1:1]};        cout = a[0];        end
      OP_RAL: begin res = {a[DATA_W-2:0], cin};         cout = a[DATA_W-1]; end
      OP_RAR: begin res = {cin, a[DATA_W-1:1]};         cout = a[0];        end
      default: begin res = a; cout = cin; end
    endcase
  end
endmodule

// File: rtl/acc_flag_reg.sv
module acc_flag_reg
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_we,
  input  logic [DATA_W-1:0] acc_d,
  input  logic              flag_we,
  input  logic [FLAG_W-1:0] flag_d,
  input  logic              flag_ld,
  input  logic [FLAG_W-1:0] flag_in,
  output logic [DATA_W-1:0] acc_q,
  output logic [FLAG_W-1:0] flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      flag_q <= '0;
    end else begin
      if (acc_we)       acc_q  <= acc_d;
      if (flag_ld)      flag_q <= flag_in & FLAG_MASK;
      else if (flag_we) flag_q <= flag_d & FLAG_MASK;
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] operand,
  input  logic              flag_ld,
  input  logic [7:0]        flag_in,
  output logic [DATA_W-1:0] acc_q,
  output logic [7:0]        flag_q
);
  alu_op_e op_e;
  flags_t  cur_f, nxt_f;

  logic op_arith, op_sub, op_logic, op_rot, op_cmp, op_valid;
  logic use_cin;
  logic [DATA_W-1:0] arith_res, logic_res, result;
  logic arith_cy, arith_ac, logic_cy;
  logic acc_we, flag_we;
  logic [7:0] flag_d;

  assign op_e  = alu_op_e'(op);
  assign cur_f = unpack_flags(flag_q);

  always_comb begin
    op_arith = 1'b0; op_sub = 1'b0; op_logic = 1'b0;
    op_rot   = 1'b0; op_cmp = 1'b0; use_cin  = 1'b0;
    case (op_e)
      OP_ADD: op_arith = 1'b1;
      OP_ADC: begin op_arith = 1'b1; use_cin = 1'b1; end
      OP_SUB: begin op_arith = 1'b1; op_sub = 1'b1; end
      OP_SBB: begin op_arith = 1'b1; op_sub = 1'b1; use_cin = 1'b1; end
      OP_CMP: begin op_arith = 1'b1; op_sub = 1'b1; op_cmp = 1'b1; end
      OP_AND, OP_OR, OP_XOR: op_logic = 1'b1;
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: op_rot = 1'b1;
      default: ;
    endcase
  end
  assign op_valid = op_arith | op_logic | op_rot;

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .a(acc_q), .b(operand), .cin(use_cin & cur_f.cy), .sub(op_sub),
    .res(arith_res), .carry(arith_cy), .half(arith_ac)
  );

  alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op(op_e), .a(acc_q), .b(operand), .cin(cur_f.cy),
    .res(logic_res), .cout(logic_cy)
  );

  assign result = op_arith ? arith_res : logic_res;

  always_comb begin
    nxt_f = cur_f;
    if (op_rot) begin
      nxt_f.cy = logic_cy;
    end else begin
      nxt_f.s  = result[DATA_W-1];
      nxt_f.z  = (result == '0);
      nxt_f.p  = ~^result;
      nxt_f.ac = op_arith ? arith_ac : 1'b0;
      nxt_f.cy = op_arith ? arith_cy : logic_cy;
    end
  end

  assign acc_we  = exec & op_valid & ~op_cmp;
  assign flag_we = exec & op_valid;
  assign flag_d  = pack_flags(nxt_f);

  acc_flag_reg #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .acc_we(acc_we), .acc_d(result),
    .flag_we(flag_we), .flag_d(flag_d),
    .flag_ld(flag_ld), .flag_in(flag_in),
    .acc_q(acc_q), .flag_q(flag_q)
  );
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec,
  input logic [3:0]        op,
  input logic              flag_ld,
  input logic [7:0]        flag_in,
  input logic [DATA_W-1:0] acc_q,
  input logic [7:0]        flag_q,
  input logic              op_logic,
  input logic              op_rot,
  input logic              op_cmp,
  input logic              op_valid
);
  logic upd;
  assign upd = exec && !flag_ld && op_valid && !op_rot;

  AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q & 8'h2A) == 8'h00); // R10
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    flag_ld |=> flag_q == ($past(flag_in) & 8'hD5)); // R11
  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !op_cmp) |=> (flag_q[6] == (acc_q == '0)) && (flag_q[7] == acc_q[DATA_W-1])); // R4
  AST_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !op_cmp) |=> flag_q[2] == ~^acc_q); // R5
  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && op_logic) |=> !flag_q[0] && !flag_q[4]); // R7
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op_cmp) |=> $stable(acc_q)); // R8
  AST_ROT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op_rot && !flag_ld) |=> flag_q[7:1] == $past(flag_q[7:1])); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((!exec || op >= 4'd12) && !flag_ld) |=> $stable(acc_q) && $stable(flag_q)); // R12
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .flag_ld(flag_ld),
  .flag_in(flag_in), .acc_q(acc_q), .flag_q(flag_q),
  .op_logic(op_logic), .op_rot(op_rot), .op_cmp(op_cmp), .op_valid(op_valid)
);

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] operand = 8'd0;
  logic       flag_ld = 1'b0;
  logic [7:0] flag_in = 8'd0;
  logic [7:0] acc_q, flag_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] m_acc = 8'd0;
  logic [7:0] m_flg = 8'd0;

  always #2 clk = ~clk;

  acc_alu u0 (
    .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .operand(operand),
    .flag_ld(flag_ld), .flag_in(flag_in), .acc_q(acc_q), .flag_q(flag_q)
  );

  function automatic bit even_ones(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return (n % 2) == 0;
  endfunction

  // reference: next accumulator and flags from requirement text
  task automatic ref_step(input logic [7:0] a, input logic [7:0] f,
                          input logic [3:0] o, input logic [7:0] b,
                          output logic [7:0] na, output logic [7:0] nf);
    int ia, ib, ic, t, h;
    logic [7:0] r;
    bit s, z, ac, p, cy;
    ia = a; ib = b;
    s = f[7]; z = f[6]; ac = f[4]; p = f[2]; cy = f[0];
    na = a; r = a;
    ic = (o == 4'd1 || o == 4'd3) ? int'(cy) : 0;
    if (o <= 4'd3 || o == 4'd7) begin
      if (o <= 4'd1) begin
        t = ia + ib + ic; h = (ia % 16) + (ib % 16) + ic;
        cy = t > 255; ac = h > 15;
      end else begin
        t = ia - ib - ic; h = (ia % 16) - (ib % 16) - ic;
        cy = t < 0; ac = h < 0;
      end
      r = t[7:0];
      if (o != 4'd7) na = r;
      s = r[7]; z = (r == 0); p = even_ones(r);
    end else if (o <= 4'd6) begin
      r = (o == 4'd4) ? (a & b) : (o == 4'd5) ? (a | b) : (a ^ b);
      na = r; cy = 0; ac = 0; s = r[7]; z = (r == 0); p = even_ones(r);
    end else if (o <= 4'd11) begin
      case (o)
        4'd8:    begin na = {a[6:0], a[7]}; cy = a[7]; end
        4'd9:    begin na = {a[0], a[7:1]}; cy = a[0]; end
        4'd10:   begin na = {a[6:0], cy};   cy = a[7]; end
        default: begin na = {cy, a[7:1]};   cy = a[0]; end
      endcase
    end
    nf = {s, z, 1'b0, ac, 1'b0, p, 1'b0, cy};
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] o);
    if (o <= 4'd3) return "R2/R3/R6 arith";
    if (o <= 4'd6) return "R7 logic";
    if (o == 4'd7) return "R8 compare";
    if (o <= 4'd11) return "R9 rotate";
    return "R12 reserved";
  endfunction

  task automatic step(input logic [3:0] o, input logic [7:0] b, input logic ex,
                      input logic ld, input logic [7:0] fin, input string req);
    logic [7:0] na, nf;
    @(negedge clk);
    exec = ex; op = o; operand = b; flag_ld = ld; flag_in = fin;
    if (ex) ref_step(m_acc, m_flg, o, b, na, nf);
    else begin na = m_acc; nf = m_flg; end
    if (ld) nf = fin & 8'hD5;
    @(posedge clk);
    @(negedge clk);
    exec = 1'b0; flag_ld = 1'b0;
    m_acc = na; m_flg = nf;
    check({req, " acc"}, acc_q, m_acc);
    check({req, " flags"}, flag_q, m_flg);
  endtask

  task automatic set_acc(input logic [7:0] v);
    step(4'd4, 8'h00, 1'b1, 1'b0, 8'h00, "R2 and");
    step(4'd5, v, 1'b1, 1'b0, 8'h00, "R2 or");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset acc", acc_q, 8'h00);
    check("R1 reset flags", flag_q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post-reset acc", acc_q, 8'h00);
    check("R1 post-reset flags", flag_q, 8'h00);

    // R3 R4 R6: 0xFF + 1 wraps to zero with carry and half carry
    set_acc(8'hFF);
    step(4'd0, 8'h01, 1'b1, 1'b0, 8'h00, "R3 add wrap");
    // R6: nibble carry alone
    set_acc(8'h0F);
    step(4'd0, 8'h01, 1'b1, 1'b0, 8'h00, "R6 add nibble");
    // R3: ADC uses carry in
    set_acc(8'hFF);
    step(4'd0, 8'h02, 1'b1, 1'b0, 8'h00, "R3 add set cy");
    step(4'd1, 8'h00, 1'b1, 1'b0, 8'h00, "R3 adc");
    // R3 R6: borrow
    set_acc(8'h10);
    step(4'd2, 8'h01, 1'b1, 1'b0, 8'h00, "R6 sub nibble borrow");
    step(4'd2, 8'h20, 1'b1, 1'b0, 8'h00, "R3 sub borrow");
    step(4'd3, 8'h00, 1'b1, 1'b0, 8'h00, "R3 sbb");
    // R5 parity
    set_acc(8'h03);
    set_acc(8'h07);
    // R8 compare equal and less
    step(4'd7, 8'h07, 1'b1, 1'b0, 8'h00, "R8 cmp equal");
    step(4'd7, 8'h09, 1'b1, 1'b0, 8'h00, "R8 cmp below");
    // R9 rotates keep other flags
    step(4'd8, 8'h00, 1'b1, 1'b0, 8'h00, "R9 rlc");
    step(4'd11, 8'h00, 1'b1, 1'b0, 8'h00, "R9 rar");
    step(4'd10, 8'h00, 1'b1, 1'b0, 8'h00, "R9 ral");
    step(4'd9, 8'h00, 1'b1, 1'b0, 8'h00, "R9 rrc");
    // R10 flag load masks spare bits
    step(4'd0, 8'h00, 1'b0, 1'b1, 8'hFF, "R10 load");
    step(4'd9, 8'h00, 1'b1, 1'b0, 8'h00, "R9 rrc after load");
    // R11 load wins while acc still updates
    step(4'd0, 8'h33, 1'b1, 1'b1, 8'h2A, "R11 load with exec");
    // R12 reserved codes and idle
    step(4'd12, 8'h55, 1'b1, 1'b0, 8'h00, "R12 code12");
    step(4'd15, 8'hAA, 1'b1, 1'b0, 8'h00, "R12 code15");
    step(4'd0, 8'h77, 1'b0, 1'b0, 8'h00, "R12 idle");

    for (int k = 0; k < 600; k++) begin
      logic [3:0] ro;
      logic [7:0] rb, rf;
      logic rl, rx;
      ro = 4'($urandom_range(0, 15));
      rb = 8'($urandom);
      rf = 8'($urandom);
      rl = ($urandom_range(0, 9) == 0);
      rx = ($urandom_range(0, 7) != 0);
      step(ro, rb, rx, rl, rf, rl ? "R11 random load" : req_of(ro));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule